// File: doc/BRIEF.md
# Channel Enable Control Register with Set/Clear Writes

This block holds the enable bits of a group of DMA channels in one 16-bit control word. Software never loads the word directly. Every write carries an operation flag in its top bit and a bit mask in the fifteen bits below it. A flag of one sets every bit that the mask names, and a flag of zero clears them. Bits the mask does not name keep their value. Because of this, several independent agents can turn their own channels on or off without a read-modify-write sequence.

Writes and reads use two separate strobes, as if they were two register addresses. The write strobe is write-only. The read strobe captures a status copy of the stored word onto a registered read bus, and that bus holds its value between read strobes. Three enables are also brought out as separate outputs, one for each of three consumers: the display list processor (bit 7), sprite fetch (bit 5) and bitplane fetch (bit 8). They follow the stored word in the cycle after the write edge.

Top module: `chan_enable_ctl`

## Requirements
- R1: While `rst` is high and after it is released, the stored word is all zeros. The first read returns 0x0000, and `copper_en`, `sprite_en` and `bitplane_en` are 0.
- R2: A write with `wr_data[15]`=1 sets every stored bit whose position is 1 in `wr_data[14:0]` and leaves all other bits unchanged (for example 0x8120 sets bits 5 and 8).
- R3: A write with `wr_data[15]`=0 clears every stored bit whose position is 1 in `wr_data[14:0]` and leaves all other bits unchanged (for example 0x0120 clears bits 5 and 8).
- R4: A write whose mask `wr_data[14:0]` is zero changes nothing, whatever the value of bit 15.
- R5: Bit 15 is never stored. `rd_data[15]` always reads 0.
- R6: On a clock edge with `rd_en` high, `rd_data` loads the stored word. Without `rd_en`, `rd_data` holds its last value.
- R7: A read and a write at the same edge return the stored word from before that write. The write shows up on the next read.
- R8: `copper_en` equals stored bit 7, `sprite_en` equals bit 5 and `bitplane_en` equals bit 8. Each changes in the same edge as the write that alters it, and one write may change several of them (0x81A0 turns on all three).
- R9: While `wr_en` is low, `wr_data` has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control port |
| wr_data | input | 16 | Bit 15 is the set/clear flag; bits 14:0 are the mask |
| rd_en | input | 1 | Read strobe for the status port |
| rd_data | output | 16 | Registered copy of the stored word, bit 15 always 0 |
| copper_en | output | 1 | Display list processor DMA enable (bit 7) |
| sprite_en | output | 1 | Sprite DMA enable (bit 5) |
| bitplane_en | output | 1 | Bitplane DMA enable (bit 8) |

## Verification
The bench goes after the zero-mask writes with either flag value. A design that loaded the word directly would wipe or fill the register on those writes. It also sends 0xFFFF to confirm that the flag bit does not leak into storage or onto the read bus, and it drives active data with the write strobe low to show that the data lines alone change nothing. A read at the same edge as a write has to return the older word, so a design that bypassed the write into the read would fail there. Random mixes of the two strobes compare `rd_data` and the three enables against a bench model after every edge, which catches a mask or flag that was swapped or inverted.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;

  typedef struct packed {
    logic copper;
    logic sprite;
    logic bitplane;
  } chan_en_t;

  function automatic int unsigned mask_width(input int unsigned data_w);
    return data_w - 1;
  endfunction

endpackage

// File: rtl/ctl_write_decode.sv
module ctl_write_decode #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned MASK_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MASK_W-1:0] cur_word,
  output logic [MASK_W-1:0] nxt_word
);

  logic op_set;
  logic [MASK_W-1:0] sel;

  assign op_set = wr_data[DATA_W-1];
  assign sel    = wr_data[MASK_W-1:0];

  for (genvar gi = 0; gi < MASK_W; gi++) begin : g_bit
    assign nxt_word[gi] = sel[gi] ? op_set : cur_word[gi];
  end

endmodule

// File: rtl/ctl_state_reg.sv
module ctl_state_reg #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned MASK_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MASK_W-1:0] nxt_word,
  output logic [MASK_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= nxt_word;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (word_q == '0)); // R1
  AST_SET_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[DATA_W-1]) |=> ((word_q & $past(wr_data[MASK_W-1:0])) == $past(wr_data[MASK_W-1:0]))); // R2
  AST_CLEAR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[DATA_W-1]) |=> ((word_q & $past(wr_data[MASK_W-1:0])) == '0)); // R3
  AST_KEEP_UNNAMED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((word_q & ~$past(wr_data[MASK_W-1:0])) == ($past(word_q) & ~$past(wr_data[MASK_W-1:0])))); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(word_q)); // R9

endmodule

// File: rtl/ctl_read_port.sv
module ctl_read_port #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned MASK_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [MASK_W-1:0] word_q,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= {1'b0, word_q};
    end
  end

  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[MASK_W-1:0] == $past(word_q))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R6
  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_data[DATA_W-1]); // R5

endmodule

// File: rtl/ctl_enable_tap.sv
module ctl_enable_tap
  import chan_ctl_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned COPPER_BIT   = 7,
  parameter int unsigned SPRITE_BIT   = 5,
  parameter int unsigned BITPLANE_BIT = 8,
  localparam int unsigned MASK_W = DATA_W - 1
) (
  input  logic [MASK_W-1:0] word_q,
  output chan_en_t          en
);

  assign en.copper   = word_q[COPPER_BIT];
  assign en.sprite   = word_q[SPRITE_BIT];
  assign en.bitplane = word_q[BITPLANE_BIT];

endmodule

// File: rtl/chan_enable_ctl.sv
module chan_enable_ctl
  import chan_ctl_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned COPPER_BIT   = 7,
  parameter int unsigned SPRITE_BIT   = 5,
  parameter int unsigned BITPLANE_BIT = 8,
  localparam int unsigned MASK_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              copper_en,
  output logic              sprite_en,
  output logic              bitplane_en
);

  logic [MASK_W-1:0] word_q;
  logic [MASK_W-1:0] nxt_word;
  chan_en_t          en;

  ctl_write_decode #(.DATA_W(DATA_W)) u_decode (
    .wr_data  (wr_data),
    .cur_word (word_q),
    .nxt_word (nxt_word)
  );

  ctl_state_reg #(.DATA_W(DATA_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .nxt_word (nxt_word),
    .word_q   (word_q)
  );

  ctl_read_port #(.DATA_W(DATA_W)) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .word_q  (word_q),
    .rd_data (rd_data)
  );

  ctl_enable_tap #(
    .DATA_W       (DATA_W),
    .COPPER_BIT   (COPPER_BIT),
    .SPRITE_BIT   (SPRITE_BIT),
    .BITPLANE_BIT (BITPLANE_BIT)
  ) u_tap (
    .word_q (word_q),
    .en     (en)
  );

  assign copper_en   = en.copper;
  assign sprite_en   = en.sprite;
  assign bitplane_en = en.bitplane;

  AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[COPPER_BIT]) |=> (copper_en == $past(wr_data[DATA_W-1]))); // R8

endmodule

// File: tb/chan_enable_ctl_bench.sv
module chan_enable_ctl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        copper_en, sprite_en, bitplane_en;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [15:0] model = '0;
  logic [15:0] exp_rd = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  chan_enable_ctl u_chan_enable_ctl (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
    .rd_en (rd_en), .rd_data (rd_data), .copper_en (copper_en),
    .sprite_en (sprite_en), .bitplane_en (bitplane_en)
  );

  function automatic logic [15:0] apply_write(input logic [15:0] cur, input logic [15:0] d);
    logic [15:0] m;
    m = {1'b0, d[14:0]};
    return d[15] ? (cur | m) : (cur & ~m);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " R8 enables"}, {13'd0, copper_en, sprite_en, bitplane_en},
          {13'd0, model[7], model[5], model[8]});
  endtask

  // one edge: drive at negedge, update model, sample at next negedge
  task automatic step(input logic we, input logic [15:0] d, input logic re);
    wr_en = we; wr_data = d; rd_en = re;
    @(posedge clk);
    if (re) exp_rd = model;
    if (we) model = apply_write(model, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd_check(input string tag);
    step(1'b0, 16'h0000, 1'b1);
    check_all(tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 16'h0000);
    check("R1 reset enables", {13'd0, copper_en, sprite_en, bitplane_en}, 16'h0000);
    rst = 1'b0;
    rd_check("R1 first read");

    step(1'b1, 16'h81A0, 1'b0);
    check_all("R8 0x81A0 all on");
    rd_check("R2 set via 0x81A0");
    step(1'b1, 16'h0120, 1'b0);
    rd_check("R3 clear 0x0120");
    step(1'b1, 16'h8120, 1'b0);
    rd_check("R2 set 0x8120");
    step(1'b1, 16'h8000, 1'b0);
    rd_check("R4 zero mask set flag");
    step(1'b1, 16'h0000, 1'b0);
    rd_check("R4 zero mask clear flag");
    step(1'b1, 16'hFFFF, 1'b0);
    rd_check("R5 0xFFFF flag not stored");
    step(1'b0, 16'h7FFF, 1'b0);
    rd_check("R9 idle data ignored");
    step(1'b1, 16'h0080, 1'b1);
    check_all("R7 read same edge as write");
    step(1'b0, 16'h0000, 1'b0);
    check_all("R6 hold without rd_en");
    rd_check("R7 write visible next read");

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      d = $urandom;
      if ((i % 17) == 0) d[14:0] = '0;
      step($urandom_range(0, 1) == 1, d, $urandom_range(0, 2) != 0);
      check_all("R2 R3 R6 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule